// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of a packet receiver and makes one decision per packet: keep it or throw it away. While armed, it looks at the first data word that arrives, together with the receive status bits that come with that word. A packet that the receiver has already flagged as damaged is discarded before its address is considered. Otherwise the destination byte, which is the upper byte of that first word, is compared with the station address. A zero destination is broadcast and is always taken. A destination equal to the station address is taken. A station address of zero makes the station promiscuous, so it takes every packet that is not damaged.

In the cycle after the first word, a taken packet produces an accept pulse and a hold-transmit pulse, and it sets a sticky arrival flag that the transmit side reads and later clears. A discarded packet produces a purge pulse instead, which tells the receive front end to drop the remaining words. In both cases the filter then ignores the rest of the packet. The word that carries the end-of-packet marker arms it again for the next packet.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, accept_o, purge_o, xmit_hold_o and arrived_o are 0, and the filter is armed, so the first word after reset is evaluated.
- R2: If the first word arrives with rx_stat bit 0 (collision seen by the receiver) or rx_stat bit 1 (packet ended off a byte boundary) set, purge_o is 1 and accept_o is 0 in the following cycle. This holds whatever the addresses are.
- R3: The destination is word_dat[15:8]. A destination of 0 with clean status is accepted.
- R4: A destination equal to station_addr with clean status is accepted.
- R5: When station_addr is 0, every first word with clean status is accepted, whatever its destination.
- R6: A first word with clean status that none of R3 to R5 accepts gives purge_o = 1 and accept_o = 0 in the following cycle.
- R7: An accepted first word gives accept_o = 1 and xmit_hold_o = 1 for exactly the one cycle that follows the word.
- R8: arrived_o goes to 1 in the same cycle that accept_o goes to 1. It stays 1 until arrived_clr is sampled high, and it reads 0 from the cycle after that. When an accepted first word and arrived_clr arrive in the same cycle, the flag is set.
- R9: Only the first word after reset, or the first word after a word with word_last = 1, is evaluated. Other words produce no accept_o, purge_o or xmit_hold_o pulse and leave arrived_o unchanged. A single-word packet (a first word with word_last = 1) leaves the filter armed for the next word.
- R10: accept_o and purge_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| word_vld | input | 1 | A received word is present this cycle |
| word_last | input | 1 | The present word is the last of its packet |
| word_dat | input | 16 | Received data word; the destination is in the upper byte |
| rx_stat | input | 2 | Receive status: bit 0 collision seen by receiver, bit 1 bad termination |
| station_addr | input | 8 | Station address; 0 selects promiscuous mode |
| arrived_clr | input | 1 | Clears the arrival flag |
| accept_o | output | 1 | Pulse: the current packet is taken |
| purge_o | output | 1 | Pulse: purge command for the rest of the packet |
| xmit_hold_o | output | 1 | Pulse: disable-transmit command issued on acceptance |
| arrived_o | output | 1 | Sticky flag: a packet was taken since the last clear |

## Verification
Each verdict pulse is registered once, so accept_o, purge_o and xmit_hold_o are due exactly one clock edge after the first word is sampled. The bench drives every word on a falling edge and reads these outputs on the very next falling edge. It reads them again one edge later to confirm that the pulse has ended. arrived_o changes at the same edge as accept_o and is checked in that same sample. A clear takes effect one edge after arrived_clr is sampled, so the bench reads the flag on the falling edge that follows the clear pulse. The sweep covers all 256 destinations and all four status codes for four station addresses, with expected verdicts worked out from the acceptance rules.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Default receive status layout: one bit per damage indication.
  localparam int RXF_STAT_W    = 2;
  localparam int RXF_JAM_IDX   = 0;
  localparam int RXF_ALIGN_IDX = 1;

  typedef enum logic {
    VERDICT_DROP = 1'b0,
    VERDICT_TAKE = 1'b1
  } verdict_e;

  typedef enum logic {
    PHASE_ARMED = 1'b0,
    PHASE_INPKT = 1'b1
  } phase_e;

endpackage

// File: rtl/rxf_classify.sv
// Combinational packet verdict from status, destination and station address.
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STAT_W    = RXF_STAT_W,
  parameter int JAM_IDX   = RXF_JAM_IDX,
  parameter int ALIGN_IDX = RXF_ALIGN_IDX
) (
  input  logic [ADDR_W-1:0] dest_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [ADDR_W-1:0] station_i,
  output verdict_e          verdict_o
);

  localparam logic [STAT_W-1:0] BAD_MASK =
    STAT_W'((1 << JAM_IDX) | (1 << ALIGN_IDX));

  logic [ADDR_W-1:0] bit_same;
  logic              damaged;
  logic              dest_bcast;
  logic              dest_hit;
  logic              promisc;

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_cmp
    assign bit_same[gi] = ~(dest_i[gi] ^ station_i[gi]);
  end

  assign damaged    = |(stat_i & BAD_MASK);
  assign dest_bcast = ~|dest_i;
  assign dest_hit   = &bit_same;
  assign promisc    = ~|station_i;

  always_comb begin
    verdict_o = VERDICT_DROP;
    if (!damaged && (dest_bcast || dest_hit || promisc)) begin
      verdict_o = VERDICT_TAKE;
    end
  end

endmodule

// File: rtl/rxf_phase.sv
// Tracks whether the next word opens a packet.
module rxf_phase
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic word_vld,
  input  logic word_last,
  output logic armed_o,
  output logic sample_o
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (word_vld) begin
      phase_d = word_last ? PHASE_ARMED : PHASE_INPKT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PHASE_ARMED;
    end else if (word_vld) begin
      phase_q <= phase_d;
    end
  end

  assign armed_o  = (phase_q == PHASE_ARMED);
  assign sample_o = word_vld && armed_o;

endmodule

// File: rtl/rxf_flag.sv
// Sticky flag; a set wins over a clear in the same cycle.
module rxf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rx_dest_filter.sv
// Receive destination address filter: one verdict per packet.
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int STAT_W    = RXF_STAT_W,
  parameter int JAM_IDX   = RXF_JAM_IDX,
  parameter int ALIGN_IDX = RXF_ALIGN_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic              word_last,
  input  logic [WORD_W-1:0] word_dat,
  input  logic [STAT_W-1:0] rx_stat,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              arrived_clr,
  output logic              accept_o,
  output logic              purge_o,
  output logic              xmit_hold_o,
  output logic              arrived_o
);

  localparam int LOW_W = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] dest_w;
  logic              armed_w;
  logic              sample_w;
  verdict_e          verdict_w;
  logic              take_w;
  logic              drop_w;

  logic acc_q, acc_d;
  logic prg_q, prg_d;
  logic hld_q, hld_d;

  assign dest_w = word_dat[WORD_W-1 -: ADDR_W];

  if (LOW_W > 0) begin : g_low
    logic unused_low;
    assign unused_low = ^word_dat[LOW_W-1:0];
  end

  rxf_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .word_last(word_last),
    .armed_o  (armed_w),
    .sample_o (sample_w)
  );

  rxf_classify #(
    .ADDR_W   (ADDR_W),
    .STAT_W   (STAT_W),
    .JAM_IDX  (JAM_IDX),
    .ALIGN_IDX(ALIGN_IDX)
  ) u_classify (
    .dest_i   (dest_w),
    .stat_i   (rx_stat),
    .station_i(station_addr),
    .verdict_o(verdict_w)
  );

  assign take_w = sample_w && (verdict_w == VERDICT_TAKE);
  assign drop_w = sample_w && (verdict_w == VERDICT_DROP);

  always_comb begin
    acc_d = take_w;
    hld_d = take_w;
    prg_d = drop_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      prg_q <= 1'b0;
      hld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      prg_q <= prg_d;
      hld_q <= hld_d;
    end
  end

  rxf_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (take_w),
    .clr_i (arrived_clr),
    .flag_o(arrived_o)
  );

  assign accept_o    = acc_q;
  assign purge_o     = prg_q;
  assign xmit_hold_o = hld_q;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int ADDR_W    = 8,
  parameter int STAT_W    = 2,
  parameter int JAM_IDX   = 0,
  parameter int ALIGN_IDX = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_vld,
  input logic              armed,
  input logic [ADDR_W-1:0] dest,
  input logic [STAT_W-1:0] rx_stat,
  input logic              arrived_clr,
  input logic              accept_o,
  input logic              purge_o,
  input logic              arrived_o
);

  assert_damaged_purged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && armed && (rx_stat[JAM_IDX] || rx_stat[ALIGN_IDX]))
      |=> (purge_o && !accept_o));

  assert_broadcast_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && armed && (rx_stat == '0) && (dest == '0)) |=> accept_o);

  assert_pulse_after_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o || purge_o) |-> $past(word_vld));

  assert_flag_with_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> arrived_o);

  assert_flag_fall_by_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arrived_o) |-> $past(arrived_clr));

  assert_inner_word_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !armed) |=> (!accept_o && !purge_o));

  assert_verdict_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && purge_o));

endmodule

bind rx_dest_filter rxf_checker #(
  .ADDR_W   (ADDR_W),
  .STAT_W   (STAT_W),
  .JAM_IDX  (JAM_IDX),
  .ALIGN_IDX(ALIGN_IDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_vld   (word_vld),
  .armed      (armed_w),
  .dest       (dest_w),
  .rx_stat    (rx_stat),
  .arrived_clr(arrived_clr),
  .accept_o   (accept_o),
  .purge_o    (purge_o),
  .arrived_o  (arrived_o)
);

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        word_vld;
  logic        word_last;
  logic [15:0] word_dat;
  logic [1:0]  rx_stat;
  logic [7:0]  station_addr;
  logic        arrived_clr;
  logic        accept_o;
  logic        purge_o;
  logic        xmit_hold_o;
  logic        arrived_o;

  int n_cmp;
  int n_bad;
  bit done;

  rx_dest_filter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_vld    (word_vld),
    .word_last   (word_last),
    .word_dat    (word_dat),
    .rx_stat     (rx_stat),
    .station_addr(station_addr),
    .arrived_clr (arrived_clr),
    .accept_o    (accept_o),
    .purge_o     (purge_o),
    .xmit_hold_o (xmit_hold_o),
    .arrived_o   (arrived_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one word on a falling edge; return on the next falling edge,
  // when the registered verdict for that word is visible.
  task automatic send_word(input logic [15:0] d, input logic [1:0] s,
                           input logic l, input logic clr);
    @(negedge clk);
    word_vld    = 1'b1;
    word_dat    = d;
    rx_stat     = s;
    word_last   = l;
    arrived_clr = clr;
    @(negedge clk);
    word_vld    = 1'b0;
    word_last   = 1'b0;
    arrived_clr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    arrived_clr = 1'b1;
    @(negedge clk);
    arrived_clr = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] sta_set [4];
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    sta_set[0] = 8'h00;
    sta_set[1] = 8'h01;
    sta_set[2] = 8'h5A;
    sta_set[3] = 8'hFF;
    rst_n        = 1'b0;
    word_vld     = 1'b0;
    word_last    = 1'b0;
    word_dat     = '0;
    rx_stat      = '0;
    station_addr = 8'h5A;
    arrived_clr  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 accept", accept_o, 0);
    chk("R1 purge", purge_o, 0);
    chk("R1 hold", xmit_hold_o, 0);
    chk("R1 flag", arrived_o, 0);

    // R1/R4: first word after reset is evaluated
    send_word(16'h5A33, 2'b00, 1'b1, 1'b0);
    chk("R1 armed after reset", accept_o, 1);
    clear_flag();

    // Sweep: R2 R3 R4 R5 R6 R7 R8 R10
    for (int si = 0; si < 4; si++) begin
      station_addr = sta_set[si];
      for (int dv = 0; dv < 256; dv++) begin
        for (int sv = 0; sv < 4; sv++) begin
          logic exp_take;
          logic [7:0] dst;
          dst = 8'(dv);
          exp_take = (sv == 0) &&
                     (dst == 8'h00 || dst == sta_set[si] || sta_set[si] == 8'h00);
          send_word({dst, dst ^ 8'hA5}, 2'(sv), 1'b0, 1'b0);
          if (sv != 0) begin
            chk("R2 damaged purge", purge_o, 1);
            chk("R2 damaged no accept", accept_o, 0);
          end else if (dst == 8'h00) begin
            chk("R3 broadcast accept", accept_o, 1);
          end else if (dst == sta_set[si]) begin
            chk("R4 match accept", accept_o, 1);
          end else if (sta_set[si] == 8'h00) begin
            chk("R5 promiscuous accept", accept_o, 1);
          end else begin
            chk("R6 mismatch purge", purge_o, 1);
            chk("R6 mismatch no accept", accept_o, 0);
          end
          chk("R7 hold with accept", xmit_hold_o, int'(exp_take));
          chk("R10 verdict", {accept_o, purge_o}, exp_take ? 2 : 1);
          chk("R8 flag set", arrived_o, int'(exp_take));
          // last word of packet: silent, pulses over
          send_word({dst, 8'h00}, 2'b00, 1'b1, 1'b0);
          chk("R7 single cycle", {accept_o, purge_o, xmit_hold_o}, 0);
          chk("R8 flag held", arrived_o, int'(exp_take));
          clear_flag();
          chk("R8 flag cleared", arrived_o, 0);
        end
      end
    end

    // R9: inner word that would match is ignored
    station_addr = 8'h22;
    send_word(16'h7700, 2'b00, 1'b0, 1'b0);
    chk("R9 first word purge", purge_o, 1);
    send_word(16'h2200, 2'b00, 1'b0, 1'b0);
    chk("R9 inner word silent", {accept_o, purge_o, xmit_hold_o}, 0);
    chk("R9 flag untouched", arrived_o, 0);
    send_word(16'h0000, 2'b00, 1'b1, 1'b0);
    chk("R9 last word silent", {accept_o, purge_o}, 0);
    chk("R9 flag untouched at end", arrived_o, 0);
    // re-armed: next packet evaluated
    send_word(16'h2201, 2'b00, 1'b1, 1'b0);
    chk("R9 rearmed accept", accept_o, 1);
    // single-word packet keeps filter armed
    send_word(16'h4401, 2'b00, 1'b1, 1'b0);
    chk("R9 back-to-back purge", purge_o, 1);
    chk("R9 back-to-back flag kept", arrived_o, 1);

    // R8: flag persists while idle, set wins over clear
    repeat (5) @(negedge clk);
    chk("R8 flag persists", arrived_o, 1);
    clear_flag();
    chk("R8 cleared", arrived_o, 0);
    send_word(16'h2200, 2'b00, 1'b1, 1'b1);
    chk("R8 set wins over clear", arrived_o, 1);
    clear_flag();
    // clear alongside a purged word clears
    send_word(16'h5500, 2'b00, 1'b1, 1'b1);
    chk("R8 clear with purge", arrived_o, 0);

    // R2: damaged broadcast in promiscuous mode still purged
    station_addr = 8'h00;
    send_word(16'h0000, 2'b11, 1'b1, 1'b0);
    chk("R2 damaged broadcast purge", purge_o, 1);
    chk("R2 no flag", arrived_o, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule